// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block translates 32-bit virtual addresses for a small processor core. It holds a fully associative set of entries, and each entry maps two neighbouring virtual pages, one even and one odd, onto two physical frames of its own. A lookup request carries a virtual address, a read/write flag and the current 8-bit address-space tag. One clock later the block returns a status code, the translated physical address, and a flag that grants write permission.

Entries are loaded through a plain indexed write port. Each entry stores a variable page-size mask, a global flag that skips the address-space compare, and a valid bit and a dirty bit for each half. The block does not walk page tables and does not choose victims for replacement. Those jobs belong to whoever drives the write port.

Top module: `paired_tlb`

## Requirements
- R1: After reset every entry is cleared and `rsp_valid` is 0. A lookup of address 0 with a non-zero current tag then returns NOMATCH (2).
- R2: `rsp_valid` is 1 in the cycle after `req_valid` is 1, and 0 in the cycle after `req_valid` is 0.
- R3: An entry hits when its global flag is set or its stored tag equals `cur_asid`, and the address bits above the entry's pair mask equal the stored page-pair number. If no entry hits, the status is NOMATCH (2).
- R4: The pair mask is the 16-bit `wr_pmask` field placed on VA[28:13], ORed with ones on VA[12:0]. A mask of 0 gives a pair of two 4 KB pages.
- R5: The half is chosen by the highest bit that the pair mask covers. That is VA[12] for mask 0 and VA[14] for mask 0x0003. A set bit selects the odd frame.
- R6: A hit on a half whose valid bit is clear returns INVALID (3).
- R7: A write that hits a valid half whose dirty bit is clear returns MODIFIED (4). A read, or a write to a dirty half, returns MATCH (0). No other codes appear.
- R8: On MATCH, `rsp_pa` is the selected frame address ORed with the address bits below the selected bit. For every other status, `rsp_pa` is 0.
- R9: When several entries hit, the entry with the lowest index supplies the result.
- R10: `rsp_wr_ok` is 1 only on a MATCH whose selected half is dirty, for reads and writes alike.
- R11: A write through the port updates the indexed entry at the clock edge. A lookup issued in that same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | 4 | Entry index to load |
| wr_vpn2 | input | 32 | Page-pair virtual address |
| wr_pmask | input | 16 | Page-size mask for VA[28:13] |
| wr_asid | input | 8 | Entry address-space tag |
| wr_glob | input | 1 | Global flag |
| wr_pfn0 | input | 32 | Even frame base address |
| wr_pfn1 | input | 32 | Odd frame base address |
| wr_v0 | input | 1 | Even half valid |
| wr_v1 | input | 1 | Odd half valid |
| wr_d0 | input | 1 | Even half dirty |
| wr_d1 | input | 1 | Odd half dirty |
| req_valid | input | 1 | Lookup request |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| cur_asid | input | 8 | Current address-space tag |
| rsp_valid | output | 1 | Result valid |
| rsp_status | output | 3 | 0 MATCH, 2 NOMATCH, 3 INVALID, 4 MODIFIED |
| rsp_pa | output | 32 | Physical address |
| rsp_wr_ok | output | 1 | Write permitted |

## Verification
A corrupted entry field or a wrong mask shows up as a wrong status or a wrong physical address on the very next response after a lookup that touches that entry. A faulty half-select or a faulty priority choice appears only for addresses that reach the odd half or that hit more than one entry. For that reason the stimulus includes overlapping entries, a large page mask, and an entry that is overwritten and then looked up again. A write-port timing fault is seen on the response to a lookup issued in the same cycle as the load.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  localparam int VA_W   = 32;
  localparam int PM_W   = 16;
  localparam int OFS_W  = 12;
  localparam int ASID_W = 8;

  typedef enum logic [2:0] {
    ST_MATCH    = 3'd0,
    ST_BADADDR  = 3'd1,
    ST_NOMATCH  = 3'd2,
    ST_INVALID  = 3'd3,
    ST_MODIFIED = 3'd4
  } tlb_status_e;

  typedef struct packed {
    logic [VA_W-1:0]   vpn2;
    logic [PM_W-1:0]   pmask;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [VA_W-1:0]   pfn0;
    logic [VA_W-1:0]   pfn1;
    logic              v0;
    logic              v1;
    logic              d0;
    logic              d1;
  } tlb_entry_t;

  // full mask of one page pair: page-size field plus the minimum pair bits
  function automatic logic [VA_W-1:0] pair_mask(input logic [PM_W-1:0] pm);
    logic [VA_W-1:0] m;
    m = '0;
    m[OFS_W:0] = '1;
    m[OFS_W+PM_W:OFS_W+1] = pm;
    return m;
  endfunction

  // bits addressing inside one half of the pair
  function automatic logic [VA_W-1:0] half_mask(input logic [VA_W-1:0] m);
    return m >> 1;
  endfunction

  // top bit of the pair mask picks the odd half
  function automatic logic odd_half(input logic [VA_W-1:0] va, input logic [VA_W-1:0] m);
    return |(va & m & ~(m >> 1));
  endfunction
endpackage

// File: rtl/ptlb_entry_match.sv
module ptlb_entry_match
  import ptlb_pkg::*;
(
  input  tlb_entry_t        ent,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              hit,
  output logic              half_valid,
  output logic              half_dirty,
  output logic [VA_W-1:0]   pa
);
  logic [VA_W-1:0] m;
  logic            tag_eq;
  logic            asid_ok;
  logic            odd;

  always_comb begin
    m          = pair_mask(ent.pmask);
    tag_eq     = (va & ~m) == (ent.vpn2 & ~m);
    asid_ok    = ent.glob || (ent.asid == cur_asid);
    hit        = tag_eq && asid_ok;
    odd        = odd_half(va, m);
    half_valid = odd ? ent.v1 : ent.v0;
    half_dirty = odd ? ent.d1 : ent.d0;
    pa         = (odd ? ent.pfn1 : ent.pfn0) | (va & half_mask(m));
  end
endmodule

// File: rtl/ptlb_prio.sv
module ptlb_prio #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
    end
    any = |req;
  end
endmodule

// File: rtl/paired_tlb.sv
module paired_tlb
  import ptlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_vpn2,
  input  logic [PM_W-1:0]   wr_pmask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic [VA_W-1:0]   wr_pfn0,
  input  logic [VA_W-1:0]   wr_pfn1,
  input  logic              wr_v0,
  input  logic              wr_v1,
  input  logic              wr_d0,
  input  logic              wr_d1,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              rsp_valid,
  output logic [2:0]        rsp_status,
  output logic [VA_W-1:0]   rsp_pa,
  output logic              rsp_wr_ok
);
  tlb_entry_t             ents [NUM_ENT];
  logic [NUM_ENT-1:0]     hit_vec;
  logic [NUM_ENT-1:0]     val_vec;
  logic [NUM_ENT-1:0]     dty_vec;
  logic [VA_W-1:0]        pa_vec [NUM_ENT];
  logic [NUM_ENT-1:0]     grant;
  logic [IDX_W-1:0]       win_idx;
  logic                   any_hit;
  tlb_status_e            nxt_status;
  logic [VA_W-1:0]        nxt_pa;
  logic                   nxt_wr_ok;

  // entry storage, loaded by index
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) ents[i] <= '0;
    end else if (wr_en) begin
      ents[wr_idx] <= '{vpn2: wr_vpn2, pmask: wr_pmask, asid: wr_asid,
                        glob: wr_glob, pfn0: wr_pfn0, pfn1: wr_pfn1,
                        v0: wr_v0, v1: wr_v1, d0: wr_d0, d1: wr_d1};
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    ptlb_entry_match u_match (
      .ent        (ents[g]),
      .va         (req_va),
      .cur_asid   (cur_asid),
      .hit        (hit_vec[g]),
      .half_valid (val_vec[g]),
      .half_dirty (dty_vec[g]),
      .pa         (pa_vec[g])
    );
  end

  ptlb_prio #(.N(NUM_ENT)) u_prio (
    .req   (hit_vec),
    .grant (grant),
    .idx   (win_idx),
    .any   (any_hit)
  );

  always_comb begin
    nxt_pa    = '0;
    nxt_wr_ok = 1'b0;
    if (!any_hit)                                   nxt_status = ST_NOMATCH;
    else if (!val_vec[win_idx])                     nxt_status = ST_INVALID;
    else if (req_write && !dty_vec[win_idx])        nxt_status = ST_MODIFIED;
    else begin
      nxt_status = ST_MATCH;
      nxt_pa     = pa_vec[win_idx];
      nxt_wr_ok  = dty_vec[win_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_NOMATCH;
      rsp_pa     <= '0;
      rsp_wr_ok  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_status <= nxt_status;
        rsp_pa     <= nxt_pa;
        rsp_wr_ok  <= nxt_wr_ok;
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_WROK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wr_ok) |-> (rsp_status == ST_MATCH)); // R10
  AST_PA_ZERO_ELSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != ST_MATCH) |-> (rsp_pa == '0)); // R8
  AST_LEGAL_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status == ST_MATCH || rsp_status == ST_NOMATCH ||
                   rsp_status == ST_INVALID || rsp_status == ST_MODIFIED)); // R7
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R9
  AST_GRANT_IN_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~hit_vec) == '0); // R9
endmodule

// File: tb/test_paired_tlb.sv
module test_paired_tlb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_vpn2 = '0;
  logic [15:0] wr_pmask = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_glob = 1'b0;
  logic [31:0] wr_pfn0 = '0;
  logic [31:0] wr_pfn1 = '0;
  logic        wr_v0 = 1'b0, wr_v1 = 1'b0, wr_d0 = 1'b0, wr_d1 = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic [7:0]  cur_asid = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_status;
  logic [31:0] rsp_pa;
  logic        rsp_wr_ok;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paired_tlb i_paired_tlb (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2),
    .wr_pmask(wr_pmask), .wr_asid(wr_asid), .wr_glob(wr_glob), .wr_pfn0(wr_pfn0),
    .wr_pfn1(wr_pfn1), .wr_v0(wr_v0), .wr_v1(wr_v1), .wr_d0(wr_d0), .wr_d1(wr_d1),
    .req_valid(req_valid), .req_va(req_va), .req_write(req_write), .cur_asid(cur_asid),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_pa(rsp_pa), .rsp_wr_ok(rsp_wr_ok)
  );

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic [7:0]  asid;
    logic [2:0]  st;
    logic [31:0] pa;
    logic        ok;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0001_0123, 1'b0, 8'h12, 3'd0, 32'h0040_0123, 1'b1}, // R5 even, R10 dirty
    '{32'h0001_1456, 1'b1, 8'h12, 3'd4, 32'h0000_0000, 1'b0}, // R7 write clean odd
    '{32'h0001_1456, 1'b0, 8'h12, 3'd0, 32'h0050_0456, 1'b0}, // R8 odd frame, clean read
    '{32'h0001_0123, 1'b0, 8'h34, 3'd0, 32'h0060_0123, 1'b1}, // R3 other tag
    '{32'h0001_0123, 1'b0, 8'h56, 3'd2, 32'h0000_0000, 1'b0}, // R3 tag mismatch
    '{32'h0040_2ABC, 1'b0, 8'h77, 3'd0, 32'h0100_2ABC, 1'b1}, // R4 global, big mask
    '{32'h0040_5000, 1'b1, 8'h77, 3'd3, 32'h0000_0000, 1'b0}, // R6 odd invalid via VA[14]
    '{32'h0040_8000, 1'b0, 8'h77, 3'd2, 32'h0000_0000, 1'b0}, // R4 above mask
    '{32'h0002_0FFF, 1'b1, 8'h09, 3'd0, 32'h0090_0FFF, 1'b1}, // R9 lowest of 3 and 5
    '{32'h0002_1000, 1'b0, 8'h09, 3'd3, 32'h0000_0000, 1'b0}, // R9 entry 3 odd invalid
    '{32'h0001_0123, 1'b1, 8'h12, 3'd0, 32'h0040_0123, 1'b1}, // R7 write dirty
    '{32'h0004_0000, 1'b0, 8'h12, 3'd2, 32'h0000_0000, 1'b0}  // R3 no entry
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [31:0] vpn, input logic [15:0] pm,
                      input logic [7:0] asid, input logic g,
                      input logic [31:0] p0, input logic [31:0] p1,
                      input logic v0, input logic v1, input logic d0, input logic d1);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn2 = vpn; wr_pmask = pm; wr_asid = asid;
    wr_glob = g; wr_pfn0 = p0; wr_pfn1 = p1; wr_v0 = v0; wr_v1 = v1; wr_d0 = d0; wr_d1 = d1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic wr, input logic [7:0] asid,
                        input logic [2:0] st, input logic [31:0] pa, input logic ok,
                        input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr; cur_asid = asid;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " status"}, 32'(rsp_status), 32'(st));
    check({tag, " pa"}, rsp_pa, pa);
    check({tag, " wr_ok"}, 32'(rsp_wr_ok), 32'(ok));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    lookup(32'h0, 1'b0, 8'h05, 3'd2, 32'h0, 1'b0, "R1 cleared entries");
    @(negedge clk);
    check("R2 idle cycle", 32'(rsp_valid), 32'd0);

    load(0, 32'h0001_0000, 16'h0000, 8'h12, 1'b0, 32'h0040_0000, 32'h0050_0000, 1, 1, 1, 0);
    load(1, 32'h0040_0000, 16'h0003, 8'h00, 1'b1, 32'h0100_0000, 32'h0200_0000, 1, 0, 1, 0);
    load(2, 32'h0001_0000, 16'h0000, 8'h34, 1'b0, 32'h0060_0000, 32'h0070_0000, 1, 1, 1, 1);
    load(5, 32'h0002_0000, 16'h0000, 8'h00, 1'b1, 32'h0080_0000, 32'h0088_0000, 1, 1, 1, 1);
    load(3, 32'h0002_0000, 16'h0000, 8'h00, 1'b1, 32'h0090_0000, 32'h0098_0000, 1, 0, 1, 1);

    for (int k = 0; k < NV; k++) begin
      lookup(VECS[k].va, VECS[k].wr, VECS[k].asid, VECS[k].st, VECS[k].pa, VECS[k].ok,
             $sformatf("R3/R5/R7/R8/R10 table %0d", k));
    end

    // R11: lookup issued in the load cycle sees the old contents
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd7; wr_vpn2 = 32'h0030_0000; wr_pmask = '0; wr_asid = 8'h21;
    wr_glob = 1'b0; wr_pfn0 = 32'h0A00_0000; wr_pfn1 = 32'h0B00_0000;
    wr_v0 = 1; wr_v1 = 1; wr_d0 = 0; wr_d1 = 1;
    req_valid = 1'b1; req_va = 32'h0030_1010; req_write = 1'b1; cur_asid = 8'h21;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R11 same-cycle status", 32'(rsp_status), 32'd2);
    lookup(32'h0030_1010, 1'b1, 8'h21, 3'd0, 32'h0B00_0010, 1'b1, "R11 after load");
    lookup(32'h0030_0010, 1'b0, 8'h21, 3'd0, 32'h0A00_0010, 1'b0, "R10 read clean half");

    // R9: entry 3 made tag-private, entry 5 now wins for other tags
    load(3, 32'h0002_0000, 16'h0000, 8'h99, 1'b0, 32'h0090_0000, 32'h0098_0000, 1, 0, 1, 1);
    lookup(32'h0002_0FFF, 1'b0, 8'h09, 3'd0, 32'h0080_0FFF, 1'b1, "R9 fall to entry 5");
    lookup(32'h0002_0FFF, 1'b0, 8'h99, 3'd0, 32'h0090_0FFF, 1'b1, "R9 entry 3 by tag");

    // R4/R5: mask 0x0003 gives a 32 KB pair, VA[14] selects, offset keeps VA[13:0]
    lookup(32'h0040_7FFC, 1'b0, 8'h00, 3'd3, 32'h0, 1'b0, "R5 odd half top");
    lookup(32'h0040_3FFC, 1'b1, 8'h00, 3'd0, 32'h0100_3FFC, 1'b1, "R4 even half top");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule